// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus cycles for an 8-bit processor core that addresses a 16-bit space. The core raises a request carrying an address, a direction, a memory-or-I/O choice and, for writes, a data byte. The block then drives one bus cycle on the pins. The upper address byte has its own lines. The lower address byte and the data byte take turns on one shared set of lines, and an address latch strobe tells outside logic when to capture the low address.

A cycle always runs T1, T2, any number of wait clocks, and then T3. A slow device stretches the cycle by holding READY low. An external master can take the bus with a HOLD/HLDA handshake. The controller grants the bus only between transfers. It floats its outputs one clock after acknowledging and drives them again half a clock after the acknowledge falls. Pad cells are outside the block, so high impedance appears here as two output-enable signals.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: In T1, the clock after a request is accepted, `bus_ale` is 1, `bus_ad_out` carries address bits 7:0, `bus_a_hi` carries address bits 15:8, `bus_ad_oe` is 1, and both strobes are high.
- R2: A read (`core_we`=0) holds `bus_rd_n` low from T2 through T3, with `bus_ad_oe`=0. The value on `bus_ad_in` at the edge where `bus_rd_n` rises is presented on `core_rdata` from the clock after T3.
- R3: A write (`core_we`=1) holds `bus_wr_n` low from T2 through T3, with `bus_ad_oe`=1 and `bus_ad_out` equal to the write byte.
- R4: Each clock edge in T2 or in a wait clock that samples `bus_ready` low adds one wait clock. The strobe is therefore low for exactly 2 + (number of low samples) clocks.
- R5: `bus_iom` equals `core_io` (1 = I/O, 0 = memory) from T1 to the end of the cycle and stays constant over it. `bus_rd_n` and `bus_wr_n` are never low together.
- R6: A HOLD raised during a cycle does not cut it short. `bus_hlda` stays 0 until the cycle ends and rises at the end of the first idle clock after T3.
- R7: One clock after `bus_hlda` rises, `bus_oe` and `bus_ad_oe` are 0 and stay 0 while the grant lasts. No strobe or `bus_ale` pulse occurs in that time, even if a core request is pending.
- R8: If HOLD and a new core request appear in the same idle clock, the hold is granted and the request waits.
- R9: `bus_hlda` falls at the first rising edge that samples HOLD low. `bus_oe` returns at the following falling edge, and a pending request enters T1 at the next rising edge.
- R10: After reset: `bus_ale`=0, `bus_rd_n`=`bus_wr_n`=1, `bus_hlda`=0, `bus_oe`=1, `bus_ad_oe`=0, `core_done`=0, `core_rdata`=0.
- R11: `core_done` is high for exactly one clock per cycle, during T3. The core keeps its request fields steady until that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core requests a bus cycle (held until `core_done`) |
| core_we | input | 1 | 1 = write, 0 = read |
| core_io | input | 1 | 1 = I/O space, 0 = memory |
| core_addr | input | 16 | Cycle address |
| core_wdata | input | 8 | Write byte |
| core_done | output | 1 | Cycle finishes this clock (T3) |
| core_rdata | output | 8 | Byte captured by the last read |
| bus_ready | input | 1 | Device ready; low inserts wait clocks |
| bus_hold | input | 1 | External master requests the bus |
| bus_hlda | output | 1 | Hold acknowledge |
| bus_a_hi | output | 8 | Upper address lines |
| bus_ad_out | output | 8 | Shared lines, driven value |
| bus_ad_in | input | 8 | Shared lines, received value |
| bus_ad_oe | output | 1 | Output enable for shared lines |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_iom | output | 1 | Memory/I/O select |
| bus_oe | output | 1 | Output enable for upper address, strobes and select |

## Verification
Two functions can fall in the same idle clock: starting a pending core cycle and granting a hold. The bench raises `bus_hold` and `core_req` at the same falling edge and checks that the acknowledge wins, that no ALE pulse leaks out, and that T1 follows only after retake. In a second case, HOLD arrives in T1 of a stretched read. The bench judges that the strobe length, the captured byte and the late acknowledge all match the completed-transfer rule, and it checks the half-clock timing of the float and the retake.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
// Shared types for the multiplexed bus cycle controller.
// Assumes: phases are encoded in 3 bits; idle must be zero so reset lands there.
package xbus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4
    } phase_t;
endpackage

// File: rtl/xbus_phase_fsm.sv
`timescale 1ns/1ps
// Bus phase sequencer: IDLE -> T1 -> T2 -> (TW)* -> T3 -> IDLE.
// Latches the request fields when a cycle starts, so the pins stay
// steady for the whole cycle. A cycle never starts while a hold is
// requested or granted. Assumes READY is synchronous to clk.
module xbus_phase_fsm
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic              hold_block,
    output phase_t            phase,
    output logic              cyc_we,
    output logic              cyc_io,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_wdata,
    output logic              xfer_done,
    output logic              in_idle
);
    phase_t phase_q, phase_d;
    logic   start;

    assign start = (phase_q == PH_IDLE) && req && !hold_block;

    // Next-phase selection; READY is looked at only in T2 and wait clocks.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (start) phase_d = PH_T1;
            PH_T1:   phase_d = PH_T2;
            PH_T2:   phase_d = ready ? PH_T3 : PH_TW;
            PH_TW:   phase_d = ready ? PH_T3 : PH_TW;
            PH_T3:   phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Capture the request fields at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_we    <= 1'b0;
            cyc_io    <= 1'b0;
            cyc_addr  <= '0;
            cyc_wdata <= '0;
        end else if (start) begin
            cyc_we    <= req_we;
            cyc_io    <= req_io;
            cyc_addr  <= req_addr;
            cyc_wdata <= req_wdata;
        end
    end

    assign phase     = phase_q;
    assign xfer_done = (phase_q == PH_T3);
    assign in_idle   = (phase_q == PH_IDLE);
endmodule

// File: rtl/xbus_hold_arb.sv
`timescale 1ns/1ps
// Hold handshake: grants the bus only while the sequencer is idle.
// Outputs float one clock after the acknowledge rises and come back at the
// falling edge that follows the acknowledge dropping (half a clock).
// Assumes HOLD is synchronous to clk.
module xbus_hold_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic fsm_idle,
    output logic hlda,
    output logic hold_block,
    output logic drive_en
);
    logic hlda_q;
    logic float_q;
    logic retake_q;

    // Acknowledge: set at a transfer boundary, kept while HOLD stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hlda_q  <= 1'b0;
            float_q <= 1'b0;
        end else begin
            hlda_q  <= hold && (hlda_q || fsm_idle);
            float_q <= hlda_q;
        end
    end

    // Falling-edge copy of the acknowledge, for the half-clock retake.
    always_ff @(negedge clk) begin
        if (!rst_n) retake_q <= 1'b0;
        else        retake_q <= hlda_q;
    end

    assign hlda       = hlda_q;
    assign hold_block = hold || hlda_q;
    assign drive_en   = !(float_q && retake_q);
endmodule

// File: rtl/xbus_pin_drv.sv
`timescale 1ns/1ps
// Pin driver: turns phase and latched cycle fields into address, shared
// line, strobe and select values, and captures read data when the read
// strobe ends. Assumes ADDR_W > DATA_W.
module xbus_pin_drv
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  phase_t                   phase,
    input  logic                     cyc_we,
    input  logic                     cyc_io,
    input  logic [ADDR_W-1:0]        cyc_addr,
    input  logic [DATA_W-1:0]        cyc_wdata,
    input  logic                     drive_en,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     iom,
    output logic                     ctl_oe,
    output logic [DATA_W-1:0]        rdata
);
    logic in_t1;
    logic strobe_ph;

    assign in_t1     = (phase == PH_T1);
    assign strobe_ph = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);

    assign ale    = in_t1;
    assign a_hi   = cyc_addr[ADDR_W-1:DATA_W];
    assign ad_out = in_t1 ? cyc_addr[DATA_W-1:0] : cyc_wdata;
    assign ad_oe  = drive_en && (in_t1 || (strobe_ph && cyc_we));
    assign rd_n   = !(strobe_ph && !cyc_we);
    assign wr_n   = !(strobe_ph && cyc_we);
    assign iom    = cyc_io;
    assign ctl_oe = drive_en;

    // Read capture at the edge where the read strobe rises (end of T3).
    always_ff @(posedge clk) begin
        if (!rst_n)                          rdata <= '0;
        else if ((phase == PH_T3) && !cyc_we) rdata <= ad_in;
    end
endmodule

// File: rtl/xbus_cycle_ctrl.sv
`timescale 1ns/1ps
// Multiplexed bus cycle controller top: joins the phase sequencer, the
// hold arbiter and the pin driver. The core holds its request until
// core_done. High impedance is signalled by bus_oe and bus_ad_oe.
module xbus_cycle_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     core_req,
    input  logic                     core_we,
    input  logic                     core_io,
    input  logic [ADDR_W-1:0]        core_addr,
    input  logic [DATA_W-1:0]        core_wdata,
    output logic                     core_done,
    output logic [DATA_W-1:0]        core_rdata,
    input  logic                     bus_ready,
    input  logic                     bus_hold,
    output logic                     bus_hlda,
    output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
    output logic [DATA_W-1:0]        bus_ad_out,
    input  logic [DATA_W-1:0]        bus_ad_in,
    output logic                     bus_ad_oe,
    output logic                     bus_ale,
    output logic                     bus_rd_n,
    output logic                     bus_wr_n,
    output logic                     bus_iom,
    output logic                     bus_oe
);
    import xbus_pkg::*;

    phase_t            phase_w;
    logic              cyc_we_w;
    logic              cyc_io_w;
    logic [ADDR_W-1:0] cyc_addr_w;
    logic [DATA_W-1:0] cyc_wdata_w;
    logic              idle_w;
    logic              block_w;
    logic              drive_w;

    xbus_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (core_req),
        .req_we     (core_we),
        .req_io     (core_io),
        .req_addr   (core_addr),
        .req_wdata  (core_wdata),
        .ready      (bus_ready),
        .hold_block (block_w),
        .phase      (phase_w),
        .cyc_we     (cyc_we_w),
        .cyc_io     (cyc_io_w),
        .cyc_addr   (cyc_addr_w),
        .cyc_wdata  (cyc_wdata_w),
        .xfer_done  (core_done),
        .in_idle    (idle_w)
    );

    xbus_hold_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (bus_hold),
        .fsm_idle   (idle_w),
        .hlda       (bus_hlda),
        .hold_block (block_w),
        .drive_en   (drive_w)
    );

    xbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase_w),
        .cyc_we    (cyc_we_w),
        .cyc_io    (cyc_io_w),
        .cyc_addr  (cyc_addr_w),
        .cyc_wdata (cyc_wdata_w),
        .drive_en  (drive_w),
        .ad_in     (bus_ad_in),
        .a_hi      (bus_a_hi),
        .ad_out    (bus_ad_out),
        .ad_oe     (bus_ad_oe),
        .ale       (bus_ale),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .iom       (bus_iom),
        .ctl_oe    (bus_oe),
        .rdata     (core_rdata)
    );
endmodule

// File: rtl/xbus_cycle_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the bus cycle controller, bound to the top.
// Observes pins plus the sequencer phase; drives nothing.
module xbus_cycle_ctrl_chk
    import xbus_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input phase_t phase,
    input logic   core_done,
    input logic   bus_ready,
    input logic   bus_hold,
    input logic   bus_hlda,
    input logic   bus_ad_oe,
    input logic   bus_ale,
    input logic   bus_rd_n,
    input logic   bus_wr_n,
    input logic   bus_iom,
    input logic   bus_oe
);
    // R1
    ale_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_ad_oe && bus_rd_n && bus_wr_n));

    // R4
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((phase == PH_T2) || (phase == PH_TW)) && !bus_ready) |=> (phase == PH_TW));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R5
    select_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase != PH_IDLE) && (phase != PH_T1)) |-> $stable(bus_iom));

    // R6
    grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hlda |-> ((phase == PH_IDLE) && bus_rd_n && bus_wr_n && !bus_ale));

    // R7
    float_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_hlda) |=> (!bus_oe && !bus_ad_oe));

    // R9
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_hlda) |-> !$past(bus_hold));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);
endmodule

bind xbus_cycle_ctrl xbus_cycle_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase_w),
    .core_done (core_done),
    .bus_ready (bus_ready),
    .bus_hold  (bus_hold),
    .bus_hlda  (bus_hlda),
    .bus_ad_oe (bus_ad_oe),
    .bus_ale   (bus_ale),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_iom   (bus_iom),
    .bus_oe    (bus_oe)
);

// File: tb/xbus_cycle_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: vector table of cycles, then directed hold cases.
module xbus_cycle_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic        core_io = 1'b0;
    logic [15:0] core_addr = '0;
    logic [7:0]  core_wdata = '0;
    logic        core_done;
    logic [7:0]  core_rdata;
    logic        bus_ready = 1'b1;
    logic        bus_hold = 1'b0;
    logic        bus_hlda;
    logic [7:0]  bus_a_hi;
    logic [7:0]  bus_ad_out;
    logic [7:0]  bus_ad_in = '0;
    logic        bus_ad_oe;
    logic        bus_ale;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic        bus_iom;
    logic        bus_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xbus_cycle_ctrl u_xbus_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_io(core_io), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_done(core_done), .core_rdata(core_rdata), .bus_ready(bus_ready),
        .bus_hold(bus_hold), .bus_hlda(bus_hlda), .bus_a_hi(bus_a_hi),
        .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in), .bus_ad_oe(bus_ad_oe),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_iom(bus_iom), .bus_oe(bus_oe)
    );

    // {we, io, addr[15:0], wdata[7:0], waits[3:0], read byte[7:0]}
    localparam logic [37:0] VECS [6] = '{
        {1'b0, 1'b0, 16'h12A5, 8'h00, 4'd0, 8'h3C},
        {1'b1, 1'b0, 16'hFF01, 8'h5A, 4'd0, 8'h00},
        {1'b0, 1'b1, 16'h0080, 8'h00, 4'd3, 8'hC3},
        {1'b1, 1'b1, 16'h7E42, 8'h81, 4'd2, 8'h00},
        {1'b0, 1'b0, 16'h0000, 8'h00, 4'd1, 8'hFF},
        {1'b1, 1'b0, 16'hFFFF, 8'h00, 4'd5, 8'h00}
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // One full cycle from an idle negedge; returns at the negedge after T3.
    task automatic run_cycle(input logic we, input logic io, input logic [15:0] addr,
                             input logic [7:0] wd, input int waits, input logic [7:0] rin,
                             input bit hold_in_t1);
        int  lowcnt = 0;
        int  guard  = 0;
        bit  seen   = 0;
        core_req = 1'b1; core_we = we; core_io = io; core_addr = addr;
        core_wdata = wd; bus_ready = 1'b1; bus_ad_in = rin;
        @(posedge clk); @(negedge clk);
        chk("R1", "ale in T1", bus_ale, 1);
        chk("R1", "low addr", bus_ad_out, addr[7:0]);
        chk("R1", "high addr", bus_a_hi, addr[15:8]);
        chk("R1", "ad_oe in T1", bus_ad_oe, 1);
        chk("R5", "select T1", bus_iom, io);
        if (hold_in_t1) bus_hold = 1'b1;
        while (!seen && guard < 64) begin
            @(posedge clk); @(negedge clk);
            guard++;
            if (we ? !bus_wr_n : !bus_rd_n) lowcnt++;
            chk("R5", "other strobe", we ? bus_rd_n : bus_wr_n, 1);
            chk("R5", "select steady", bus_iom, io);
            chk(we ? "R3" : "R2", "ad_oe data phase", bus_ad_oe, we);
            if (we) chk("R3", "write byte", bus_ad_out, wd);
            if (hold_in_t1) chk("R6", "no grant mid cycle", bus_hlda, 0);
            if (core_done) begin
                seen = 1;
                core_req = 1'b0;
            end else begin
                bus_ready = (lowcnt <= waits) ? 1'b0 : 1'b1;
            end
        end
        bus_ready = 1'b1;
        chk("R4", "strobe clocks", lowcnt, waits + 2);
        @(posedge clk); @(negedge clk);
        chk("R11", "done single", core_done, 0);
        chk(we ? "R3" : "R2", "strobes released", {bus_rd_n, bus_wr_n}, 2'b11);
        if (!we) chk("R2", "read capture", core_rdata, rin);
    endtask

    // Wait for T3 of a pending cycle, drop the request, step one clock.
    task automatic finish_cycle();
        int guard = 0;
        while (!core_done && guard < 64) begin
            @(posedge clk); @(negedge clk);
            guard++;
        end
        core_req = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "ale", bus_ale, 0);
        chk("R10", "strobes", {bus_rd_n, bus_wr_n}, 2'b11);
        chk("R10", "hlda", bus_hlda, 0);
        chk("R10", "bus_oe", bus_oe, 1);
        chk("R10", "ad_oe", bus_ad_oe, 0);
        chk("R10", "done", core_done, 0);
        chk("R10", "rdata", core_rdata, 0);

        for (int i = 0; i < 6; i++) begin
            run_cycle(VECS[i][37], VECS[i][36], VECS[i][35:20], VECS[i][19:12],
                      int'(VECS[i][11:8]), VECS[i][7:0], 1'b0);
        end

        // R6/R7/R9: hold raised in T1 of a stretched read
        run_cycle(1'b0, 1'b0, 16'hA55A, 8'h00, 2, 8'h96, 1'b1);
        chk("R6", "hlda first idle", bus_hlda, 0);
        @(posedge clk); @(negedge clk);
        chk("R6", "hlda after idle", bus_hlda, 1);
        chk("R7", "still driving", bus_oe, 1);
        core_req = 1'b1; core_we = 1'b1; core_io = 1'b0;
        core_addr = 16'h3412; core_wdata = 8'hE7;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R7", "floated", {bus_oe, bus_ad_oe}, 2'b00);
            chk("R7", "no ale", bus_ale, 0);
            chk("R7", "no strobe", {bus_rd_n, bus_wr_n}, 2'b11);
        end
        bus_hold = 1'b0;
        @(posedge clk); #2;
        chk("R9", "hlda fell", bus_hlda, 0);
        chk("R9", "still floated", bus_oe, 0);
        @(negedge clk); #2;
        chk("R9", "retake half clock", bus_oe, 1);
        chk("R9", "no T1 yet", bus_ale, 0);
        @(posedge clk); @(negedge clk);
        chk("R9", "pending T1", bus_ale, 1);
        chk("R9", "pending addr", bus_ad_out, 8'h12);
        finish_cycle();

        // R8: hold and request in the same idle clock
        core_req = 1'b1; core_we = 1'b0; core_io = 1'b1;
        core_addr = 16'h00C7; bus_ad_in = 8'h4D; bus_hold = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8", "hold wins", bus_hlda, 1);
        chk("R8", "request waits", bus_ale, 0);
        @(posedge clk); @(negedge clk);
        chk("R8", "still no ale", bus_ale, 0);
        bus_hold = 1'b0;
        @(posedge clk); @(negedge clk); #2;
        chk("R8", "idle at drop", bus_ale, 0);
        chk("R9", "driving again", bus_oe, 1);
        @(posedge clk); @(negedge clk);
        chk("R8", "deferred T1", bus_ale, 1);
        chk("R8", "deferred select", bus_iom, 1);
        finish_cycle();
        chk("R8", "deferred read", core_rdata, 8'h4D);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule